// File: doc/BRIEF.md
# Line Signal Quality Monitor

This block judges the health of a received serial line. A symbol decoder in front of it pulses `bad_sym` for one clock whenever it sees a symbol it cannot accept. The monitor splits time into fixed windows of reference clocks. At the end of each window it moves a saturating up/down level counter by one step. A window that saw any bad symbol pushes the level toward "bad". A clean window pulls it toward "good".

The good-signal flag has hysteresis. It turns on only when the level reaches the bottom of its range and turns off only when the level reaches the top. Between those two points it keeps its last value. A line therefore needs a run of qualifying windows before its status changes. Every change of the flag sets a sticky interrupt-pending bit, which software clears by pulsing `irq_clr`.

Top module: `line_quality_mon`

## Requirements
- R1: Synchronous reset, while asserted, forces `level` to CNT_MAX (7), `good` to 0 and `irq_pend` to 0.
- R2: A window is WINDOW_LEN clock cycles long, starting with the first clock edge after reset is released. `level` changes only on the last edge of a window, so it holds its value at every other edge.
- R3: At the end of a window in which `bad_sym` was never high, `level` decreases by one.
- R4: At the end of a window in which `bad_sym` was high in at least one cycle, `level` increases by one, whatever the number or position of the pulses.
- R5: `level` saturates: it stays at 0 after a clean window and stays at CNT_MAX after a window with bad symbols.
- R6: `good` becomes 1 on the same edge that `level` becomes 0. It becomes 0 on the same edge that `level` becomes CNT_MAX. At any other level, `good` keeps its previous value.
- R7: A `bad_sym` pulse on the final cycle of a window counts toward the window that is closing. A pulse on the first cycle of the next window counts only toward that next window.
- R8: `irq_pend` becomes 1 on the edge where `good` changes value and stays 1 until it is cleared by `irq_clr`.
- R9: When `irq_clr` is high on an edge where `good` does not change, `irq_pend` becomes 0. When it is high on an edge where `good` changes, `irq_pend` stays 1, because the set wins.
- R10: Starting from reset, CNT_MAX consecutive clean windows are needed and enough for `good` to rise. From level 0, CNT_MAX consecutive bad windows are needed and enough for `good` to fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bad_sym | input | 1 | One-cycle strobe for each bad symbol received |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt-pending bit |
| good | output | 1 | Registered good-signal status |
| level | output | $clog2(CNT_MAX+1) | Registered quality level, 0 = best |
| irq_pend | output | 1 | Sticky flag for a change of status |

## Verification
A window timer off by one cycle moves the boundary pulse into the wrong window. The level then drifts from the expected sequence at the first window whose only bad pulse sits on a boundary cycle, and the error shows at the very next window close. If the level counter does not saturate, or steps by the wrong amount, `level` is wrong at the window close where the fault occurs. If the hysteresis logic keys on the wrong level, `good` and `irq_pend` change one or more windows too early or too late. A long pseudo-random run of windows makes each of these show within a few hundred cycles.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/lsm_window_timer.sv
module lsm_window_timer #(
  parameter int WINDOW_LEN = 1024
) (
  input  logic clk,
  input  logic rst,
  output logic win_end
);
  localparam int CW = (WINDOW_LEN > 1) ? $clog2(WINDOW_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(WINDOW_LEN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign win_end = (cnt_q == LAST);

  generate
    if (WINDOW_LEN > 1) begin : g_gap
      // R2
      win_gap_chk: assert property (@(posedge clk) disable iff (rst)
        win_end |=> !win_end);
    end
  endgenerate
endmodule

// File: rtl/lsm_bad_latch.sv
module lsm_bad_latch (
  input  logic clk,
  input  logic rst,
  input  logic bad_sym,
  input  logic win_end,
  output logic window_bad
);
  logic seen_q;

  // pulse on the closing cycle still counts for the closing window
  assign window_bad = seen_q | bad_sym;

  always_ff @(posedge clk) begin
    if (rst)          seen_q <= 1'b0;
    else if (win_end) seen_q <= 1'b0;
    else              seen_q <= window_bad;
  end
endmodule

// File: rtl/lsm_level_counter.sv
module lsm_level_counter
  import lsm_pkg::*;
#(
  parameter int CNT_MAX = 7,
  localparam int LW = $clog2(CNT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          win_end,
  input  logic          window_bad,
  output logic [LW-1:0] level_q,
  output logic [LW-1:0] level_nxt
);
  localparam logic [LW-1:0] TOP = LW'(CNT_MAX);

  step_e step;

  always_comb begin
    step = STEP_HOLD;
    if (win_end) begin
      if (window_bad && level_q != TOP)      step = STEP_UP;
      else if (!window_bad && level_q != '0) step = STEP_DOWN;
    end
  end

  always_comb begin
    unique case (step)
      STEP_UP:   level_nxt = level_q + 1'b1;
      STEP_DOWN: level_nxt = level_q - 1'b1;
      default:   level_nxt = level_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) level_q <= TOP;
    else     level_q <= level_nxt;
  end

  // R2
  level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !win_end |=> $stable(level_q));
  // R5
  level_range_chk: assert property (@(posedge clk) disable iff (rst)
    win_end |=> (level_q <= TOP) &&
      ((level_q == $past(level_q) + 1'b1) || (level_q + 1'b1 == $past(level_q)) ||
       (level_q == $past(level_q))));
endmodule

// File: rtl/line_quality_mon.sv
module line_quality_mon #(
  parameter int WINDOW_LEN = 1024,
  parameter int CNT_MAX    = 7,
  localparam int LW = $clog2(CNT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bad_sym,
  input  logic          irq_clr,
  output logic          good,
  output logic [LW-1:0] level,
  output logic          irq_pend
);
  localparam logic [LW-1:0] TOP = LW'(CNT_MAX);

  logic          win_end;
  logic          window_bad;
  logic [LW-1:0] level_nxt;
  logic          good_nxt;
  logic          changed;

  lsm_window_timer #(.WINDOW_LEN(WINDOW_LEN)) u_timer (
    .clk(clk), .rst(rst), .win_end(win_end)
  );

  lsm_bad_latch u_latch (
    .clk(clk), .rst(rst), .bad_sym(bad_sym),
    .win_end(win_end), .window_bad(window_bad)
  );

  lsm_level_counter #(.CNT_MAX(CNT_MAX)) u_level (
    .clk(clk), .rst(rst), .win_end(win_end), .window_bad(window_bad),
    .level_q(level), .level_nxt(level_nxt)
  );

  always_comb begin
    good_nxt = good;
    if (level_nxt == '0)     good_nxt = 1'b1;
    else if (level_nxt == TOP) good_nxt = 1'b0;
  end

  assign changed = (good_nxt != good);

  always_ff @(posedge clk) begin
    if (rst) begin
      good     <= 1'b0;
      irq_pend <= 1'b0;
    end else begin
      good     <= good_nxt;
      irq_pend <= changed | (irq_pend & ~irq_clr);
    end
  end

  // R6
  good_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(good) |-> level == '0);
  // R6
  good_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(good) |-> level == TOP);
  // R8
  irq_on_change_chk: assert property (@(posedge clk) disable iff (rst)
    (good != $past(good)) |-> irq_pend);
  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_pend && !irq_clr) |=> irq_pend);
endmodule

// File: tb/line_quality_mon_test.sv
module line_quality_mon_test;
  localparam int W  = 16;
  localparam int MX = 7;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bad_sym = 1'b0;
  logic       irq_clr = 1'b0;
  logic       good;
  logic [2:0] level;
  logic       irq_pend;

  int checks = 0;
  int failures = 0;
  int m_lvl, m_good, m_irq;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  line_quality_mon #(.WINDOW_LEN(W), .CNT_MAX(MX)) uut (
    .clk(clk), .rst(rst), .bad_sym(bad_sym), .irq_clr(irq_clr),
    .good(good), .level(level), .irq_pend(irq_pend)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one full window; bad pulses at bp0/bp1 (-1 = none), clear at cp (-1 = none)
  task automatic run_window(input int bp0, input int bp1, input int cp);
    bit any_bad = (bp0 >= 0) || (bp1 >= 0);
    bit clr_early = (cp >= 0) && (cp < W - 1);
    bit clr_last  = (cp == W - 1);
    int old_good = m_good;
    for (int i = 0; i < W; i++) begin
      bad_sym = (i == bp0) || (i == bp1);
      irq_clr = (i == cp);
      @(negedge clk);
      if (i == W / 2) chk(level == 3'(m_lvl), "R2 mid-window hold", level, m_lvl);
      if (clr_early && i == cp) m_irq = 0;
    end
    bad_sym = 1'b0;
    irq_clr = 1'b0;
    if (any_bad) m_lvl = (m_lvl < MX) ? m_lvl + 1 : MX;
    else         m_lvl = (m_lvl > 0) ? m_lvl - 1 : 0;
    if (m_lvl == 0) m_good = 1;
    else if (m_lvl == MX) m_good = 0;
    if (m_good != old_good) m_irq = 1;
    else if (clr_last) m_irq = 0;
    chk(level == 3'(m_lvl), any_bad ? "R4/R5 level after bad window" : "R3/R5 level after clean window", level, m_lvl);
    chk(good == m_good, "R6 good flag", good, m_good);
    chk(irq_pend == m_irq, "R8/R9 irq pending", irq_pend, m_irq);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    m_lvl = MX; m_good = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    chk(level == 3'(MX), "R1 reset level", level, MX);
    chk(good == 1'b0, "R1 reset good", good, 0);
    chk(irq_pend == 1'b0, "R1 reset irq", irq_pend, 0);
    rst = 1'b0;

    // R10: six clean windows keep good low, the seventh raises it
    for (int k = 0; k < MX; k++) begin
      run_window(-1, -1, -1);
      if (k < MX - 1) chk(good == 1'b0, "R10 not yet good", good, 0);
    end
    chk(good == 1'b1, "R10 good after seven clean windows", good, 1);
    // R9: clear on an edge with no change
    run_window(-1, -1, 3);
    chk(irq_pend == 1'b0, "R9 clear works", irq_pend, 0);
    // R5 floor, clear while nothing pending
    run_window(-1, -1, 0);
    // R7: pulse on last cycle counts toward closing window
    run_window(W - 1, -1, -1);
    chk(level == 3'd1, "R7 boundary pulse counted", level, 1);
    // R7: pulse on first cycle counts only toward its own window
    run_window(0, -1, -1);
    run_window(-1, -1, -1);
    chk(level == 3'd1, "R7 first-cycle pulse in own window", level, 1);
    // R4: multiple pulses count once
    run_window(2, 9, -1);
    chk(level == 3'd2, "R4 several pulses one step", level, 2);
    // climb to bad; R9 clear on last cycle of the transition window loses
    for (int k = 0; k < 4; k++) run_window(5, -1, -1);
    run_window(1, -1, W - 1);
    chk(good == 1'b0 && irq_pend == 1'b1, "R9 set wins over clear", irq_pend, 1);
    run_window(4, -1, -1);
    chk(level == 3'(MX), "R5 ceiling", level, MX);

    // pseudo-random sweep with alternating bias
    for (int n = 0; n < 240; n++) begin
      int b0, b1, cp;
      bit mode = (n / 14) % 2;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (mode) b0 = (lfsr[2:0] != 0) ? int'(lfsr[7:4]) : -1;
      else      b0 = (lfsr[2:0] == 0) ? int'(lfsr[7:4]) : -1;
      b1 = (b0 >= 0 && lfsr[3]) ? int'(lfsr[15:12]) : -1;
      cp = (lfsr[9:8] == 0) ? int'(lfsr[13:10]) : -1;
      run_window(b0, b1, cp);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule